// File: doc/BRIEF.md
# Re-Reference Interval Replacement Controller

This block holds the replacement state of a set-associative cache and chooses which way a new line displaces. Every line carries a 2-bit reuse prediction value. A value of 0 marks a line expected back very soon. A value of 3 marks a line whose reuse is far off, so it may be evicted. A hit pulls the line's value to 0. When a fill needs a slot, the controller looks for a way that holds no line, and failing that, for a way predicted distant. If it finds neither, it ages the whole set one step per clock until a candidate appears.

The cache controller raises a fill request with the set index and the per-way presence mask from its tag array. It waits for `victim_valid`, uses `victim_way`, and pulses `fill_ack` once the line is placed. On that acknowledge the controller writes the new line's starting prediction. A mode input picks the insertion policy. In static mode every new line starts at value 2. In bimodal mode most new lines start at 3, which makes a streaming scan evict itself first, and a line starts at 2 once every 32 fills.

Top module: `rrip_repl`

## Requirements
- R1: After reset every prediction value is 3, so a fill to a set whose ways are all present offers way 0 one clock after the request is sampled.
- R2: If the presence mask has any way cleared, the offered way is the lowest-numbered cleared way, whatever the prediction values are.
- R3: If every way is present, the offered way is the lowest-numbered way whose prediction value is 3.
- R4: If every way is present and none holds 3, all values in the set rise by one per clock and the search repeats. `victim_valid` rises at most 4 clocks after the request is sampled, provided no hit targets that set during the search.
- R5: A hit sets the prediction value of the addressed set and way to 0.
- R6: With `bimodal_mode` at 0 when `fill_ack` is sampled, the installed way gets value 2.
- R7: A 5-bit fill counter is 0 after reset and advances by one, wrapping, on every acknowledged fill in either mode. With `bimodal_mode` at 1, the installed way gets value 2 when the counter reads 0 before the advance, and gets value 3 otherwise.
- R8: While `victim_valid` is high and `fill_ack` is low, `victim_way` does not change. `victim_valid` falls on the clock that samples `fill_ack`.
- R9: A hit or fill in one set leaves the prediction values of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bimodal_mode | input | 1 | 0 selects static insertion, 1 selects bimodal insertion |
| hit_valid | input | 1 | Hit strobe |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | WAY_W | Way index of the hit |
| fill_req | input | 1 | Request for a victim, held until acknowledged |
| fill_set | input | SET_W | Set index of the fill |
| fill_line_valid | input | NUM_WAYS | Per-way presence mask of the fill set, 1 means a line is present |
| fill_ack | input | 1 | Fill done; installs the new line's prediction value |
| victim_valid | output | 1 | Offered way is ready |
| victim_way | output | WAY_W | Offered way |

## Verification
Fills to untouched sets with a full mask show the reset value and the lowest-index choice. Masks with holes show that a free way beats the prediction search. Filling a set after hitting all of its ways forces three aging passes, which exposes the search latency and the step-by-step increment. Repeated fills to one set in each mode show the static start value against the bimodal one-in-32 rhythm. An acknowledge held back for several clocks tests that the offered way stays steady. A random mix of hits, fills, masks and modes across a few sets is tracked against a behavioural model of the prediction values on every clock, which also catches a hit or fill that disturbs another set.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_OFFER  = 2'd2
    } fsm_e;

    localparam logic [1:0] RRPV_NEAR = 2'd0;
    localparam logic [1:0] RRPV_LONG = 2'd2;
    localparam logic [1:0] RRPV_DIST = 2'd3;
endpackage

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][1:0] rrpv,
    input  logic [NUM_WAYS-1:0]      line_valid,
    output logic                     found,
    output logic [WAY_W-1:0]         way
);
    import rrip_pkg::*;

    logic             inv_hit, dist_hit;
    logic [WAY_W-1:0] inv_way, dist_way;

    // Scan from the top down so the lowest index is the one that sticks.
    always_comb begin
        inv_hit  = 1'b0;
        dist_hit = 1'b0;
        inv_way  = '0;
        dist_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!line_valid[w]) begin
                inv_hit = 1'b1;
                inv_way = WAY_W'(w);
            end
            if (rrpv[w] == RRPV_DIST) begin
                dist_hit = 1'b1;
                dist_way = WAY_W'(w);
            end
        end
        found = inv_hit | dist_hit;
        way   = inv_hit ? inv_way : dist_way;
    end
endmodule

// File: rtl/rrip_insert_sel.sv
module rrip_insert_sel #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       bimodal,
    output logic [1:0] ins_rrpv
);
    import rrip_pkg::*;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = advance ? cnt_q + 1'b1 : cnt_q;
        ins_rrpv = (bimodal && (cnt_q != '0)) ? RRPV_DIST : RRPV_LONG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt_q == $past(cnt_q) + 1'b1);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cnt_q));
endmodule

// File: rtl/rrip_repl.sv
module rrip_repl #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 64,
    parameter int BIP_CNT_W = 5,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bimodal_mode,
    input  logic                hit_valid,
    input  logic [SET_W-1:0]    hit_set,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                fill_req,
    input  logic [SET_W-1:0]    fill_set,
    input  logic [NUM_WAYS-1:0] fill_line_valid,
    input  logic                fill_ack,
    output logic                victim_valid,
    output logic [WAY_W-1:0]    victim_way
);
    import rrip_pkg::*;

    typedef struct packed {
        fsm_e                              state;
        logic [SET_W-1:0]                  set;
        logic [NUM_WAYS-1:0]               vmask;
        logic [WAY_W-1:0]                  way;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][1:0] rrpv;
    } regs_t;

    regs_t q, d;

    logic [SET_W-1:0]    cur_set;
    logic [NUM_WAYS-1:0] cur_mask;
    logic                pick_found;
    logic [WAY_W-1:0]    pick_way;
    logic [1:0]          ins_rrpv;
    logic                install;

    assign cur_set  = (q.state == ST_IDLE) ? fill_set        : q.set;
    assign cur_mask = (q.state == ST_IDLE) ? fill_line_valid : q.vmask;
    assign install  = (q.state == ST_OFFER) && fill_ack;

    rrip_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .rrpv       (q.rrpv[cur_set]),
        .line_valid (cur_mask),
        .found      (pick_found),
        .way        (pick_way)
    );

    rrip_insert_sel #(.CNT_W(BIP_CNT_W)) u_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (install),
        .bimodal  (bimodal_mode),
        .ins_rrpv (ins_rrpv)
    );

    always_comb begin
        d = q;
        if ((q.state == ST_SEARCH) || ((q.state == ST_IDLE) && fill_req)) begin
            d.set   = cur_set;
            d.vmask = cur_mask;
            if (pick_found) begin
                d.way   = pick_way;
                d.state = ST_OFFER;
            end else begin
                for (int w = 0; w < NUM_WAYS; w++)
                    d.rrpv[cur_set][w] = q.rrpv[cur_set][w] + 2'd1;
                d.state = ST_SEARCH;
            end
        end
        if (hit_valid)
            d.rrpv[hit_set][hit_way] = RRPV_NEAR;
        if (install) begin
            d.rrpv[q.set][q.way] = ins_rrpv;
            d.state              = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.set   <= '0;
            q.vmask <= '0;
            q.way   <= '0;
            q.rrpv  <= '1;
        end else begin
            q <= d;
        end
    end

    assign victim_valid = (q.state == ST_OFFER);
    assign victim_way   = q.way;

    // Checker state: search-pass count and last hit address.
    logic [2:0]       srch_cnt_q;
    logic             hit_chk_q;
    logic [SET_W-1:0] hit_set_q;
    logic [WAY_W-1:0] hit_way_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srch_cnt_q <= '0;
            hit_chk_q  <= 1'b0;
            hit_set_q  <= '0;
            hit_way_q  <= '0;
        end else begin
            srch_cnt_q <= (q.state == ST_SEARCH) ? srch_cnt_q + 3'd1 : 3'd0;
            hit_chk_q  <= hit_valid && !(install && hit_set == q.set && hit_way == q.way);
            hit_set_q  <= hit_set;
            hit_way_q  <= hit_way;
        end
    end

    // R8
    hold_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid && !fill_ack |=> victim_valid && $stable(victim_way));

    // R8
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid && fill_ack |=> !victim_valid);

    // R4
    search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SEARCH) |-> srch_cnt_q < 3'd3);

    // R5
    hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_chk_q |-> q.rrpv[hit_set_q][hit_way_q] == RRPV_NEAR);

    // R2 R3
    pick_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(victim_valid) |-> (!q.vmask[victim_way]) ||
                                (q.rrpv[q.set][victim_way] == RRPV_DIST));
endmodule

// File: tb/rrip_repl_tb.sv
module rrip_repl_tb;
    localparam int NW = 4;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bimodal_mode;
    logic          hit_valid;
    logic [5:0]    hit_set;
    logic [1:0]    hit_way;
    logic          fill_req;
    logic [5:0]    fill_set;
    logic [NW-1:0] fill_line_valid;
    logic          fill_ack;
    logic          victim_valid;
    logic [1:0]    victim_way;

    always #2.5 clk = ~clk;

    rrip_repl u_dut (
        .clk(clk), .rst_n(rst_n), .bimodal_mode(bimodal_mode),
        .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
        .fill_req(fill_req), .fill_set(fill_set), .fill_line_valid(fill_line_valid),
        .fill_ack(fill_ack), .victim_valid(victim_valid), .victim_way(victim_way)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Behavioural reference
    int m_rr [NS][NW];
    int m_state = 0;
    int m_set = 0;
    int m_way = 0;
    int m_cnt = 0;
    logic [NW-1:0] m_mask = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) m_rr[s][w] = 3;
            m_state = 0; m_cnt = 0; m_way = 0;
        end else begin
            int old_state;
            old_state = m_state;
            if (old_state == 1 || (old_state == 0 && fill_req)) begin
                int pick;
                if (old_state == 0) begin
                    m_set  = fill_set;
                    m_mask = fill_line_valid;
                end
                pick = -1;
                for (int w = 0; w < NW; w++)
                    if (pick < 0 && !m_mask[w]) pick = w;
                for (int w = 0; w < NW; w++)
                    if (pick < 0 && m_rr[m_set][w] == 3) pick = w;
                if (pick >= 0) begin
                    m_way = pick; m_state = 2;
                end else begin
                    for (int w = 0; w < NW; w++) m_rr[m_set][w] += 1;
                    m_state = 1;
                end
            end
            if (hit_valid) m_rr[hit_set][hit_way] = 0;
            if (old_state == 2 && fill_ack) begin
                m_rr[m_set][m_way] = (bimodal_mode && m_cnt != 0) ? 3 : 2;
                m_cnt   = (m_cnt + 1) % 32;
                m_state = 0;
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_vec++;
            if (victim_valid !== (m_state == 2) ||
                (m_state == 2 && victim_way !== 2'(m_way))) begin
                n_bad++;
                $display("FAIL %s: victim_valid/way actual %0b/%0d expected %0b/%0d",
                         cur_req, victim_valid, victim_way, (m_state == 2), m_way);
            end
        end
    end

    task automatic check_val(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_hit(int s, int w);
        @(negedge clk);
        hit_valid = 1'b1; hit_set = 6'(s); hit_way = 2'(w);
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic do_fill(int s, logic [NW-1:0] mask, bit mode, int delay,
                           output int way, output int lat);
        @(negedge clk);
        fill_req = 1'b1; fill_set = 6'(s); fill_line_valid = mask;
        bimodal_mode = mode;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!victim_valid && lat < 10);
        way = victim_way;
        repeat (delay) @(negedge clk);
        fill_req = 1'b0; fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int way, lat;
        rst_n = 1'b0; bimodal_mode = 1'b0; hit_valid = 1'b0; hit_set = '0;
        hit_way = '0; fill_req = 1'b0; fill_set = '0; fill_line_valid = '1;
        fill_ack = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1 reset victim_valid", victim_valid, 0);
        rst_n = 1'b1;

        // R1: untouched set with full mask gives way 0 after one clock
        cur_req = "R1";
        do_fill(3, 4'b1111, 1'b0, 0, way, lat);
        check_val("R1 way", way, 0);
        check_val("R1 latency", lat, 1);

        // R2: free ways 2 and 3, lowest free wins
        cur_req = "R2";
        do_fill(4, 4'b0011, 1'b0, 0, way, lat);
        check_val("R2 way", way, 2);

        // R3 R6: way 0 of set 3 now holds 2, so way 1 is next
        cur_req = "R3";
        do_fill(3, 4'b1111, 1'b0, 0, way, lat);
        check_val("R3 R6 way", way, 1);

        // R5 R4: all ways hit to 0, three aging passes then way 0
        cur_req = "R4";
        for (int w = 0; w < NW; w++) do_hit(10, w);
        do_fill(10, 4'b1111, 1'b0, 0, way, lat);
        check_val("R4 R5 way", way, 0);
        check_val("R4 latency", lat, 4);
        // after aging ways 1..3 hold 3: next fill picks way 1
        do_fill(10, 4'b1111, 1'b0, 0, way, lat);
        check_val("R4 aged way", way, 1);

        // R9: hit in set 11 must not disturb set 12
        cur_req = "R9";
        do_hit(11, 0);
        do_fill(12, 4'b1111, 1'b0, 0, way, lat);
        check_val("R9 way", way, 0);

        // R8: held acknowledge keeps the way steady
        cur_req = "R8";
        do_fill(13, 4'b1011, 1'b0, 6, way, lat);
        check_val("R8 way", way, 2);
        check_val("R8 after ack victim_valid", victim_valid, 0);

        // R7: bimodal insertion over many fills to one set
        cur_req = "R7";
        for (int i = 0; i < 40; i++) do_fill(20, 4'b1111, 1'b1, 0, way, lat);
        cur_req = "R6";
        for (int i = 0; i < 8; i++) do_fill(21, 4'b1111, 1'b0, 0, way, lat);

        // Mixed random traffic, R3 R4 R5 R9 model tracking
        cur_req = "R5";
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 0)
                do_hit($urandom_range(30, 33), $urandom_range(0, 3));
            else begin
                do_fill($urandom_range(30, 33), 4'($urandom_range(8, 15)),
                        1'($urandom_range(0, 1)), $urandom_range(0, 2), way, lat);
                check_val("R4 random latency bound", (lat <= 4), 1);
            end
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule